// File: doc/BRIEF.md
# Microcode Control Sequencer

This block steers a multicycle 32-bit load/store datapath. A micro-address register selects one word of a microcode store. The word drives the ALU operation, both operand selects, the register write target and its source, the memory command and its address source, the instruction-register load and the PC update mode. Each word also carries a 2-bit next-address select. That select either returns to fetch, jumps through an opcode dispatch table, or steps to the following micro-address.

Each instruction begins with a common fetch step and a common decode step. In decode the ALU forms the branch target while the opcode is looked up. The supported classes are register-register ALU, OR with immediate, load word, store word and branch on equal. Every other opcode dispatches to an exception step. That step loads the exception vector into the PC and flags a trap. The datapath and the exception handler lie outside this block.

Top module: `ucode_seq`

## Requirements
- R1: While `rst_n` is low, the micro-address becomes 0 at the next rising clock edge, whatever it held before.
- R2: At micro-address 0 (fetch) the word is: alu_op=0 (add), src_a=0 (PC), src_b=1 (constant four), mem_op=1 (read), addr_sel=0 (PC), ir_we=1, pc_mode=1 (unconditional ALU result), pc_we=1. The next micro-address is 1.
- R3: At micro-address 1 (decode) the word is: alu_op=0, src_a=0 (PC), src_b=4 (sign-extended offset shifted left two), with no memory, register or PC action. The next micro-address comes from the dispatch table.
- R4: The dispatch table maps opcode 0x00 to 4, 0x04 to 3, 0x0D to 6, 0x23 to 8 and 0x2B to 11. Every other opcode maps to 12.
- R5: Register-register: micro-address 4 gives alu_op=3 (function field), src_a=1 (register A), src_b=0 (register B). Micro-address 5 gives reg_dst=1 (rd) with wb_sel=0 (ALU result register). The next micro-address after 5 is 0.
- R6: OR immediate: micro-address 6 gives alu_op=2 (or), src_a=1, src_b=3 (zero-extended immediate). Micro-address 7 gives reg_dst=2 (rt) with wb_sel=0. The next micro-address after 7 is 0.
- R7: Load: micro-address 8 gives alu_op=0, src_a=1, src_b=2 (sign-extended immediate). Micro-address 9 gives mem_op=1 with addr_sel=1 (ALU result register). Micro-address 10 gives reg_dst=2 with wb_sel=1 (memory data). The next micro-address after 10 is 0.
- R8: Store: micro-address 11 gives alu_op=0, src_a=1, src_b=2, mem_op=2 (write) and addr_sel=2 (live ALU output). The next micro-address is 0. No other micro-address issues a write.
- R9: Branch: micro-address 3 gives alu_op=1 (subtract), src_a=1, src_b=0 and pc_mode=2 (conditional). pc_we equals `alu_eq` in that cycle. The next micro-address is 0.
- R10: Exception: micro-address 12 gives pc_mode=3 (vector), pc_we=1 and trap=1. The next micro-address is 0.
- R11: Every field not named for a micro-address is 0. `trap` is 1 only at micro-address 12.
- R12: The opcode affects the sequence only in the decode cycle. Outside micro-address 3, `alu_eq` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_eq | input | 1 | ALU operands equal (zero result) |
| upc | output | 4 | Current micro-address |
| alu_op | output | 2 | 0 add, 1 subtract, 2 or, 3 function field |
| src_a | output | 1 | 0 PC, 1 register A |
| src_b | output | 3 | 0 B, 1 four, 2 sign-ext, 3 zero-ext, 4 sign-ext shifted |
| reg_dst | output | 2 | 0 none, 1 rd, 2 rt |
| wb_sel | output | 1 | 0 ALU result register, 1 memory data |
| mem_op | output | 2 | 0 idle, 1 read, 2 write |
| addr_sel | output | 2 | 0 PC, 1 ALU result register, 2 live ALU output |
| ir_we | output | 1 | Load instruction register |
| pc_mode | output | 2 | 0 hold, 1 ALU, 2 if equal, 3 exception vector |
| pc_we | output | 1 | PC write enable after the condition is applied |
| trap | output | 1 | Exception step active |

## Verification
A vector table runs each supported opcode from fetch back to fetch. It checks the micro-address and the full control word at every step. This separates the five dispatch targets and the length of each path. Branch is run with the equal flag both set and clear, which tells the conditional PC write apart from a fixed one. Several unsupported opcodes test the catch-all entry at both ends of the opcode range and next to legal codes. During execution the opcode is inverted and the equal flag is toggled, which shows that both are ignored outside the cycles that use them. A directed test asserts reset in the middle of a load and holds it, which shows that reset wins over any select value.

// File: rtl/useq_pkg.sv
// Package: shared encodings and the control-word layout for the microcode
// sequencer. Assumes a 4-bit micro-address space (16 words).
package useq_pkg;

    typedef enum logic [1:0] {NS_ZERO = 2'd0, NS_DISP = 2'd1, NS_INC = 2'd2} nsel_e;
    typedef enum logic [1:0] {AL_ADD = 2'd0, AL_SUB = 2'd1, AL_OR = 2'd2, AL_FN = 2'd3} alu_e;
    typedef enum logic       {SA_PC = 1'b0, SA_REG = 1'b1} srca_e;
    typedef enum logic [2:0] {SB_REG = 3'd0, SB_FOUR = 3'd1, SB_SEXT = 3'd2,
                              SB_ZEXT = 3'd3, SB_SHFT = 3'd4} srcb_e;
    typedef enum logic [1:0] {RD_NONE = 2'd0, RD_RD = 2'd1, RD_RT = 2'd2} rdst_e;
    typedef enum logic       {WB_ALU = 1'b0, WB_MEM = 1'b1} wb_e;
    typedef enum logic [1:0] {MO_IDLE = 2'd0, MO_RD = 2'd1, MO_WR = 2'd2} mop_e;
    typedef enum logic [1:0] {AD_PC = 2'd0, AD_AOUT = 2'd1, AD_ALU = 2'd2} adr_e;
    typedef enum logic [1:0] {PM_HOLD = 2'd0, PM_ALU = 2'd1, PM_EQ = 2'd2, PM_VEC = 2'd3} pcm_e;

    typedef struct packed {
        nsel_e seq;
        alu_e  alu;
        srca_e sa;
        srcb_e sb;
        rdst_e rd;
        wb_e   wb;
        mop_e  mem;
        adr_e  ad;
        logic  ir_we;
        pcm_e  pcm;
        logic  trap;
    } ctrl_t;

    // Micro-address map: entry points are fixed by the dispatch table.
    localparam int UA_FETCH = 0;
    localparam int UA_DEC   = 1;
    localparam int UA_BEQ   = 3;
    localparam int UA_RTY   = 4;
    localparam int UA_ORI   = 6;
    localparam int UA_LW    = 8;
    localparam int UA_SW    = 11;
    localparam int UA_EXC   = 12;

    // Opcodes that have a dispatch entry.
    localparam logic [5:0] OP_RTY = 6'h00;
    localparam logic [5:0] OP_BEQ = 6'h04;
    localparam logic [5:0] OP_ORI = 6'h0D;
    localparam logic [5:0] OP_LW  = 6'h23;
    localparam logic [5:0] OP_SW  = 6'h2B;

endpackage

// File: rtl/useq_dispatch.sv
// Module: opcode dispatch table. Purely combinational; maps the opcode to
// the first micro-address of its routine. Assumes every unlisted opcode is
// illegal and must land on the exception word.
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int UA_W = 4
) (
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] target
);

    // Look up the entry point; the default covers all unused rows.
    always_comb begin
        case (opcode)
            OP_RTY:  target = UA_W'(UA_RTY);
            OP_BEQ:  target = UA_W'(UA_BEQ);
            OP_ORI:  target = UA_W'(UA_ORI);
            OP_LW:   target = UA_W'(UA_LW);
            OP_SW:   target = UA_W'(UA_SW);
            default: target = UA_W'(UA_EXC);
        endcase
    end

endmodule

// File: rtl/useq_rom.sv
// Module: microcode store. Combinational lookup of the control word at the
// current micro-address. Assumes unprogrammed addresses must be harmless:
// they drive an idle word that returns to fetch.
module useq_rom
    import useq_pkg::*;
#(
    parameter int UA_W = 4
) (
    input  logic [UA_W-1:0] addr,
    output ctrl_t           word
);

    // Assemble the word for this address starting from an all-idle word.
    always_comb begin
        word     = '0;
        word.seq = NS_ZERO;
        case (int'(addr))
            UA_FETCH: begin
                word.sa = SA_PC;  word.sb = SB_FOUR; word.alu = AL_ADD;
                word.mem = MO_RD; word.ad = AD_PC;   word.ir_we = 1'b1;
                word.pcm = PM_ALU; word.seq = NS_INC;
            end
            UA_DEC: begin
                word.sa = SA_PC; word.sb = SB_SHFT; word.alu = AL_ADD;
                word.seq = NS_DISP;
            end
            UA_BEQ: begin
                word.sa = SA_REG; word.sb = SB_REG; word.alu = AL_SUB;
                word.pcm = PM_EQ;
            end
            UA_RTY: begin
                word.sa = SA_REG; word.sb = SB_REG; word.alu = AL_FN;
                word.seq = NS_INC;
            end
            UA_RTY + 1: begin
                word.rd = RD_RD; word.wb = WB_ALU;
            end
            UA_ORI: begin
                word.sa = SA_REG; word.sb = SB_ZEXT; word.alu = AL_OR;
                word.seq = NS_INC;
            end
            UA_ORI + 1: begin
                word.rd = RD_RT; word.wb = WB_ALU;
            end
            UA_LW: begin
                word.sa = SA_REG; word.sb = SB_SEXT; word.alu = AL_ADD;
                word.seq = NS_INC;
            end
            UA_LW + 1: begin
                word.mem = MO_RD; word.ad = AD_AOUT; word.seq = NS_INC;
            end
            UA_LW + 2: begin
                word.rd = RD_RT; word.wb = WB_MEM;
            end
            UA_SW: begin
                word.sa = SA_REG; word.sb = SB_SEXT; word.alu = AL_ADD;
                word.mem = MO_WR; word.ad = AD_ALU;
            end
            UA_EXC: begin
                word.pcm = PM_VEC; word.trap = 1'b1;
            end
            default: word.seq = NS_ZERO;
        endcase
    end

endmodule

// File: rtl/useq_next.sv
// Module: micro-address register and next-address selector. Assumes the
// select comes from the word at the current address and that reset is
// synchronous and active low.
module useq_next
    import useq_pkg::*;
#(
    parameter int UA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  nsel_e           sel,
    input  logic [UA_W-1:0] disp,
    output logic [UA_W-1:0] upc
);

    logic [UA_W-1:0] nxt;

    // Pick the following micro-address from the select field.
    always_comb begin
        case (sel)
            NS_DISP: nxt = disp;
            NS_INC:  nxt = upc + 1'b1;
            default: nxt = '0;
        endcase
    end

    // Hold the micro-address; reset returns it to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= '0;
        else        upc <= nxt;
    end

endmodule

// File: rtl/ucode_seq.sv
// Module: top of the microcode control sequencer. Registers the
// micro-address, looks up the control word combinationally and resolves the
// conditional PC write with the ALU equal flag. Assumes the datapath samples
// the outputs at the next rising edge.
module ucode_seq
    import useq_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int UA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_eq,
    output logic [UA_W-1:0] upc,
    output logic [1:0]      alu_op,
    output logic            src_a,
    output logic [2:0]      src_b,
    output logic [1:0]      reg_dst,
    output logic            wb_sel,
    output logic [1:0]      mem_op,
    output logic [1:0]      addr_sel,
    output logic            ir_we,
    output logic [1:0]      pc_mode,
    output logic            pc_we,
    output logic            trap
);

    ctrl_t           cw;
    logic [UA_W-1:0] disp_tgt;

    useq_dispatch #(.OP_W(OP_W), .UA_W(UA_W)) u_disp (
        .opcode (opcode),
        .target (disp_tgt)
    );

    useq_rom #(.UA_W(UA_W)) u_rom (
        .addr (upc),
        .word (cw)
    );

    useq_next #(.UA_W(UA_W)) u_next (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (cw.seq),
        .disp  (disp_tgt),
        .upc   (upc)
    );

    // Unpack the word onto the datapath control pins.
    always_comb begin
        alu_op   = cw.alu;
        src_a    = cw.sa;
        src_b    = cw.sb;
        reg_dst  = cw.rd;
        wb_sel   = cw.wb;
        mem_op   = cw.mem;
        addr_sel = cw.ad;
        ir_we    = cw.ir_we;
        pc_mode  = cw.pcm;
        trap     = cw.trap;
    end

    // Resolve the PC write: conditional mode follows the equal flag.
    always_comb begin
        case (cw.pcm)
            PM_ALU, PM_VEC: pc_we = 1'b1;
            PM_EQ:          pc_we = alu_eq;
            default:        pc_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_chk.sv
// Module: property checker for the sequencer, bound to every instance of
// the top. Observes ports only.
module useq_chk #(
    parameter int UA_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [UA_W-1:0] upc,
    input logic            alu_eq,
    input logic            pc_we,
    input logic            trap,
    input logic [1:0]      mem_op
);

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 0 |=> upc == 1); // R2
    AST_DISPATCH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 1 |=> (upc == 3 || upc == 4 || upc == 6 || upc == 8 || upc == 11 || upc == 12)); // R4
    AST_BRANCH_COND: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 3 |-> pc_we == alu_eq); // R9
    AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 12 |-> trap && pc_we); // R10
    AST_TRAP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        upc == 12 |=> upc == 0); // R10
    AST_TRAP_ONLY_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> upc == 12); // R11
    AST_WRITE_ONLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_op == 2'd2 |-> upc == 11); // R8

endmodule

bind ucode_seq useq_chk #(.UA_W(UA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .upc    (upc),
    .alu_eq (alu_eq),
    .pc_we  (pc_we),
    .trap   (trap),
    .mem_op (mem_op)
);

// File: tb/sim_ucode_seq.sv
// Bench: walks a vector table of opcodes through complete micro-routines,
// then directed reset tests. Expected words come from the requirement text.
module sim_ucode_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       alu_eq = 1'b0;
    logic [3:0] upc;
    logic [1:0] alu_op, reg_dst, mem_op, addr_sel, pc_mode;
    logic       src_a, wb_sel, ir_we, pc_we, trap;
    logic [2:0] src_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ucode_seq u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_eq(alu_eq),
        .upc(upc), .alu_op(alu_op), .src_a(src_a), .src_b(src_b),
        .reg_dst(reg_dst), .wb_sel(wb_sel), .mem_op(mem_op),
        .addr_sel(addr_sel), .ir_we(ir_we), .pc_mode(pc_mode),
        .pc_we(pc_we), .trap(trap)
    );

    // Vector: opcode, equal flag, expected entry micro-address.
    typedef struct packed {
        logic [5:0] op;
        logic       eq;
        logic [3:0] entry;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 1'b0, 4'd4},   // R4 R5 register-register
        '{6'h04, 1'b1, 4'd3},   // R9 branch taken
        '{6'h04, 1'b0, 4'd3},   // R9 branch not taken
        '{6'h0D, 1'b1, 4'd6},   // R6
        '{6'h23, 1'b0, 4'd8},   // R7
        '{6'h2B, 1'b1, 4'd11},  // R8
        '{6'h02, 1'b0, 4'd12},  // R10 unlisted opcode
        '{6'h3F, 1'b1, 4'd12},  // R10 top of range
        '{6'h01, 1'b0, 4'd12},  // R10 neighbour of legal code
        '{6'h05, 1'b1, 4'd12},  // R10
        '{6'h2A, 1'b0, 4'd12},  // R10
        '{6'h0C, 1'b1, 4'd12}   // R10
    };

    // Expected control word {alu,sa,sb,rd,wb,mem,ad,ir,pcm,pcwe,trap} per R2..R11.
    function automatic logic [17:0] exp_word(input int a, input logic eq);
        case (a)
            0:  return {2'd0, 1'b0, 3'd1, 2'd0, 1'b0, 2'd1, 2'd0, 1'b1, 2'd1, 1'b1, 1'b0};
            1:  return {2'd0, 1'b0, 3'd4, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            3:  return {2'd1, 1'b1, 3'd0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd2, eq,   1'b0};
            4:  return {2'd3, 1'b1, 3'd0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            5:  return {2'd0, 1'b0, 3'd0, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            6:  return {2'd2, 1'b1, 3'd3, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            7:  return {2'd0, 1'b0, 3'd0, 2'd2, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            8:  return {2'd0, 1'b1, 3'd2, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            9:  return {2'd0, 1'b0, 3'd0, 2'd0, 1'b0, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0};
            10: return {2'd0, 1'b0, 3'd0, 2'd2, 1'b1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0};
            11: return {2'd0, 1'b1, 3'd2, 2'd0, 1'b0, 2'd2, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0};
            12: return {2'd0, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd3, 1'b1, 1'b1};
            default: return '0;
        endcase
    endfunction

    // Expected successor outside decode, per R5..R10.
    function automatic int exp_next(input int a);
        if (a == 5 || a == 7 || a == 10 || a == 11 || a == 3 || a == 12) return 0;
        return a + 1;
    endfunction

    function automatic logic [17:0] act_word();
        return {alu_op, src_a, src_b, reg_dst, wb_sel, mem_op, addr_sel,
                ir_we, pc_mode, pc_we, trap};
    endfunction

    task automatic chk_upc(input string req, input int exp);
        total++;
        if (int'(upc) != exp) begin
            bad++;
            $display("FAIL %s upc actual=%0d expected=%0d", req, upc, exp);
        end
    endtask

    task automatic chk_word(input string req, input int a, input logic eq);
        logic [17:0] e;
        e = exp_word(a, eq);
        total++;
        if (act_word() !== e) begin
            bad++;
            $display("FAIL %s word@%0d actual=%h expected=%h", req, a, act_word(), e);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cur;
        // R1: reset state
        repeat (3) step();
        chk_upc("R1", 0);
        chk_word("R1", 0, alu_eq);
        rst_n = 1'b1;

        // Table walk: each vector runs from fetch back to fetch.
        for (int v = 0; v < NV; v++) begin
            opcode = VECS[v].op;
            alu_eq = VECS[v].eq;
            chk_upc("R2", 0);
            chk_word("R2", 0, alu_eq);
            step();
            chk_upc("R2", 1);
            chk_word("R3", 1, alu_eq);
            step();
            chk_upc("R4", int'(VECS[v].entry));
            // R12: opcode changes after decode must not matter.
            opcode = ~VECS[v].op;
            cur = int'(VECS[v].entry);
            for (int k = 0; k < 4 && cur != 0; k++) begin
                chk_upc("R12", cur);
                chk_word((cur == 3) ? "R9" : (cur == 12) ? "R10" : "R11", cur, alu_eq);
                // R12: equal flag toggled outside the branch step.
                if (cur != 3) begin
                    alu_eq = ~alu_eq;
                    #1;
                    chk_word("R12", cur, alu_eq);
                end
                step();
                cur = exp_next(cur);
            end
            chk_upc("R5 R6 R7 R8 R9 R10 return", 0);
        end

        // R1: reset in the middle of a load.
        opcode = 6'h23;
        step();
        step();
        step();
        chk_upc("R7", 9);
        rst_n = 1'b0;
        step();
        chk_upc("R1", 0);
        step();
        step();
        chk_upc("R1", 0);
        chk_word("R1", 0, alu_eq);
        rst_n = 1'b1;
        step();
        chk_upc("R1", 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule